// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns single memory requests from an 8-bit controller core into bus cycles on a multiplexed external bus. During an address phase the low address byte goes out on a shared low port together with an address-latch strobe. A data phase follows, in which the shared port is released for reads or driven with write data. The upper address byte sits on its own port for the whole cycle. Code fetches strobe a program-store enable. Data reads and writes strobe separate read and write enables. All strobes are active low.

A cycle is normally four clocks long. A paged timing shortens cycles whose upper address byte matches the previous external access. A 2-bit speed setting picks the hit and miss lengths. A third mode applies paged timing to code fetches only. A request flagged as internal completes in one clock with no bus strobes, and it can pulse the address latch if that option is enabled. The core sees a ready signal and a one-clock done pulse that carries the read data.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, ale_o is 0, psen_no, rd_no and wr_no are 1, p0_oe_o is 0, req_ready_o is 1 and rsp_done_o is 0.
- R2: With cfg_mode_i = 00 or 11 (plain timing), an external access lasts 4 clocks. ale_o is high in the first 2 clocks and the strobe is low in the last 2.
- R3: An access with req_internal_i = 1 lasts 1 clock and asserts no strobe. ale_o pulses for that clock only if it is a code fetch (req_code_i = 1) and cfg_int_ale_i = 1.
- R4: An external code fetch always raises ale_o during its address phase, whatever cfg_int_ale_i is set to.
- R5: psen_no goes low only in the data phase of an external code fetch. rd_no goes low only for an external data read (req_code_i = 0, req_write_i = 0). wr_no goes low only for an external data write. At most one strobe is low at any time.
- R6: While ale_o is high, p0_o carries the low address byte and p0_oe_o = 1. While wr_no is low, p0_o carries the write data and p0_oe_o = 1. During read and code data phases p0_oe_o = 0. p2_o carries the upper address byte in every clock of the cycle.
- R7: p0_i is sampled in the last clock of an external read or code fetch. rsp_done_o pulses for one clock in the clock after that, and rsp_rdata_o then holds the sampled byte.
- R8: With cfg_mode_i = 01 (paged timing), cfg_speed_i = 00, 01 and 1x give hit/miss lengths of 1/2, 2/4 and 4/8 clocks. In every external cycle the first half (length / 2 clocks) is the address phase.
- R9: A page hit is an upper address byte equal to that of the previous external access. The first access after reset, or after any change of cfg_mode_i, is a miss.
- R10: With cfg_mode_i = 10, code fetches use the paged lengths of R8, while data accesses always take 4 clocks.
- R11: req_ready_o is 0 in every clock of a cycle except the last one. A request presented in the last clock is accepted there, so cycles run back to back with no gap.
- R12: A 1-clock page hit has no address phase: ale_o stays low and the strobe is low for the whole clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 2 | Timing mode: 00/11 plain, 01 paged, 10 paged for code only |
| cfg_speed_i | input | 2 | Paged length select |
| cfg_int_ale_i | input | 1 | Pulse ale_o on internal code fetches |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this clock |
| req_addr_i | input | 16 | Request address |
| req_code_i | input | 1 | 1 = code fetch, 0 = data access |
| req_write_i | input | 1 | 1 = data write |
| req_wdata_i | input | 8 | Write data |
| req_internal_i | input | 1 | Address decodes to internal memory; suppress bus |
| rsp_done_o | output | 1 | One-clock completion pulse |
| rsp_rdata_o | output | 8 | Read data, valid with rsp_done_o |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_no | output | 1 | Program store enable, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| p0_o | output | 8 | Low address / write data out |
| p0_oe_o | output | 1 | Output enable for the low port |
| p0_i | input | 8 | Read data from the low port |
| p2_o | output | 8 | Upper address byte |

## Verification
The assertions assume that req_valid_i is only sampled together with req_ready_o and that the configuration inputs do not matter once a cycle has begun. They also assume that external memory places its byte on p0_i by the last clock of a read. The stimulus presents each request at a falling edge, holds it until the next rising edge samples ready, and then withdraws it. Configuration changes are made only while the sequencer is idle, and between changes of cfg_mode_i the bench waits enough clocks for the page tracker to see each change. Read data is modelled as a fixed function of the bench's own copy of the address, so it is stable over the whole data phase.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN     = 2'b00,
    MODE_PAGE      = 2'b01,
    MODE_CODE_PAGE = 2'b10,
    MODE_PLAIN_ALT = 2'b11
  } bus_mode_e;

  typedef struct packed {
    logic code;
    logic write;
    logic internal;
    logic int_ale;
  } acc_attr_t;
endpackage

// File: rtl/ebus_page_trk.sv
module ebus_page_trk #(
  parameter int HI_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic            upd_i,
  input  logic [HI_W-1:0] hi_i,
  output logic            hit_o
);
  logic [HI_W-1:0] last_hi_q;
  logic            valid_q;
  logic [1:0]      mode_q;
  logic            mode_chg;

  assign mode_chg = (mode_i != mode_q);
  assign hit_o    = valid_q && !mode_chg && (hi_i == last_hi_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_hi_q <= '0;
      valid_q   <= 1'b0;
      mode_q    <= 2'b00;
    end else begin
      mode_q <= mode_i;
      if (upd_i) begin
        last_hi_q <= hi_i;
        valid_q   <= 1'b1;
      end else if (mode_chg) begin
        valid_q <= 1'b0;
      end
    end
  end

  // R9
  page_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> valid_q && (last_hi_q == $past(hi_i)));
endmodule

// File: rtl/ebus_len_sel.sv
module ebus_len_sel
  import ebus_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int PLAIN_LEN = 4
) (
  input  logic             internal_i,
  input  logic             code_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       speed_i,
  input  logic             hit_i,
  output logic [LEN_W-1:0] len_o
);
  logic [1:0]       spd;
  logic [LEN_W-1:0] hit_len, miss_len;
  logic             paged;
  bus_mode_e        mode;

  always_comb begin
    mode     = bus_mode_e'(mode_i);
    spd      = (speed_i == 2'b11) ? 2'd2 : speed_i;
    hit_len  = LEN_W'(1) << spd;
    miss_len = hit_len << 1;
    paged    = (mode == MODE_PAGE) || ((mode == MODE_CODE_PAGE) && code_i);
    if (internal_i)  len_o = LEN_W'(1);
    else if (paged)  len_o = hit_i ? hit_len : miss_len;
    else             len_o = LEN_W'(PLAIN_LEN);
  end
endmodule

// File: rtl/ebus_phase_ctr.sv
module ebus_phase_ctr #(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [LEN_W-1:0] cnt_o,
  output logic [LEN_W-1:0] half_o
);
  logic [LEN_W-1:0] cnt_q, len_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign half_o = len_q >> 1;
  assign last_o = busy_q && (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      len_q  <= LEN_W'(1);
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      len_q  <= len_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (last_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + LEN_W'(1);
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < len_q));
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_mode_i,
  input  logic [1:0]        cfg_speed_i,
  input  logic              cfg_int_ale_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_code_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_internal_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] p0_o,
  output logic              p0_oe_o,
  input  logic [DATA_W-1:0] p0_i,
  output logic [ADDR_W-DATA_W-1:0] p2_o
);
  localparam int HI_W      = ADDR_W - DATA_W;
  localparam int PLAIN_LEN = 4;
  localparam int MAX_LEN   = 8;
  localparam int LEN_W     = $clog2(MAX_LEN + 1);

  logic              accept, hit, busy, last;
  logic [LEN_W-1:0]  len_nxt, cnt, half;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  acc_attr_t         attr_q;
  logic              done_q;
  logic              addr_ph, data_ph, int_ale_ph, is_read;

  assign req_ready_o = !busy || last;
  assign accept      = req_valid_i && req_ready_o;

  ebus_page_trk #(.HI_W(HI_W)) i_page_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (cfg_mode_i),
    .upd_i  (accept && !req_internal_i),
    .hi_i   (req_addr_i[ADDR_W-1:DATA_W]),
    .hit_o  (hit)
  );

  ebus_len_sel #(.LEN_W(LEN_W), .PLAIN_LEN(PLAIN_LEN)) i_len_sel (
    .internal_i (req_internal_i),
    .code_i     (req_code_i),
    .mode_i     (cfg_mode_i),
    .speed_i    (cfg_speed_i),
    .hit_i      (hit),
    .len_o      (len_nxt)
  );

  ebus_phase_ctr #(.LEN_W(LEN_W)) i_phase_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .len_i   (len_nxt),
    .busy_o  (busy),
    .last_o  (last),
    .cnt_o   (cnt),
    .half_o  (half)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      attr_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      attr_q  <= '{code: req_code_i, write: req_write_i,
                   internal: req_internal_i, int_ale: cfg_int_ale_i};
    end
  end

  // phase decode from registered state
  assign addr_ph    = busy && !attr_q.internal && (cnt < half);
  assign data_ph    = busy && !attr_q.internal && !addr_ph;
  assign int_ale_ph = busy && attr_q.internal && attr_q.code && attr_q.int_ale;
  assign is_read    = attr_q.code || !attr_q.write;

  assign ale_o   = addr_ph || int_ale_ph;
  assign psen_no = !(data_ph && attr_q.code);
  assign rd_no   = !(data_ph && !attr_q.code && !attr_q.write);
  assign wr_no   = !(data_ph && !attr_q.code && attr_q.write);
  assign p0_oe_o = ale_o || !wr_no;
  assign p0_o    = ale_o ? addr_q[DATA_W-1:0] : (!wr_no ? wdata_q : '0);
  assign p2_o    = addr_q[ADDR_W-1:DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= last;
      if (last && !attr_q.internal && is_read) rdata_q <= p0_i;
    end
  end

  assign rsp_done_o  = done_q;
  assign rsp_rdata_o = rdata_q;

  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> (rd_no && wr_no));
  // R6
  ale_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (psen_no && rd_no && wr_no));
  // R6
  wr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (p0_oe_o && (p0_o == wdata_q)));
  // R6
  p2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !last) |=> $stable(p2_o));
  // R11
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> $past(req_ready_o));
  // R3
  int_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && attr_q.internal) |-> (psen_no && rd_no && wr_no && last));
endmodule

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  cfg_mode = 2'b00, cfg_speed = 2'b00;
  logic        cfg_int_ale = 1'b0;
  logic        req_valid = 1'b0, req_code = 1'b0, req_write = 1'b0, req_internal = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done, ale, psen_n, rd_n, wr_n, p0_oe;
  logic [7:0]  rsp_rdata, p0_out, p0_in, p2;
  logic [15:0] b_addr = '0;

  int checks = 0;
  int errors = 0;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign p0_in = mem_f(b_addr);

  ext_bus_seq i_ext_bus_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_mode_i(cfg_mode), .cfg_speed_i(cfg_speed), .cfg_int_ale_i(cfg_int_ale),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_code_i(req_code), .req_write_i(req_write), .req_wdata_i(req_wdata),
    .req_internal_i(req_internal), .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .ale_o(ale), .psen_no(psen_n), .rd_no(rd_n), .wr_no(wr_n),
    .p0_o(p0_out), .p0_oe_o(p0_oe), .p0_i(p0_in), .p2_o(p2)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // one access from idle; exp_len computed by caller from the requirements
  task automatic access(input logic [15:0] a, input bit code, input bit wr,
                        input logic [7:0] wd, input bit intl, input int exp_len,
                        input string req);
    int n = 0, n_ale = 0, n_psen = 0, n_rd = 0, n_wr = 0;
    int exp_ale, exp_dat;
    bit bad_p0 = 0, bad_p2 = 0, bad_rdy = 0, bad_oe = 0, bad_early = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready when idle", req_ready, 1);
    req_addr = a; req_code = code; req_write = wr; req_wdata = wd;
    req_internal = intl; b_addr = a; req_valid = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      if (rsp_done) break;
      if (ale) begin
        n_ale++;
        if (n_psen + n_rd + n_wr != 0) bad_early = 1;
        if (!(p0_oe && p0_out == a[7:0])) bad_p0 = 1;
      end
      if (!psen_n) begin n_psen++; if (p0_oe) bad_oe = 1; end
      if (!rd_n)   begin n_rd++;   if (p0_oe) bad_oe = 1; end
      if (!wr_n)   begin n_wr++;   if (!(p0_oe && p0_out == wd)) bad_p0 = 1; end
      if (!intl && p2 != a[15:8]) bad_p2 = 1;
      if (req_ready != (n == exp_len - 1)) bad_rdy = 1;
      n++;
    end
    if (intl) begin
      exp_ale = (code && cfg_int_ale) ? 1 : 0;
      exp_dat = 0;
    end else begin
      exp_ale = exp_len / 2;
      exp_dat = exp_len - exp_len / 2;
    end
    chk(n == exp_len, req, "cycle length", n, exp_len);
    chk(n_ale == exp_ale, req, "ale clocks", n_ale, exp_ale);
    chk(n_psen == ((code && !intl) ? exp_dat : 0), "R5", "psen clocks", n_psen,
        (code && !intl) ? exp_dat : 0);
    chk(n_rd == ((!code && !wr && !intl) ? exp_dat : 0), "R5", "rd clocks", n_rd,
        (!code && !wr && !intl) ? exp_dat : 0);
    chk(n_wr == ((!code && wr && !intl) ? exp_dat : 0), "R5", "wr clocks", n_wr,
        (!code && wr && !intl) ? exp_dat : 0);
    chk(!bad_early, "R2", "strobe before ale ended", bad_early, 0);
    chk(!bad_p0, "R6", "p0 drive", bad_p0, 0);
    chk(!bad_oe, "R6", "p0 released on read", bad_oe, 0);
    chk(!bad_p2, "R6", "p2 upper byte", bad_p2, 0);
    chk(!bad_rdy, "R11", "ready only in last clock", bad_rdy, 0);
    chk(rsp_done == 1'b1, "R7", "done pulse", rsp_done, 1);
    if (!intl && (code || !wr))
      chk(rsp_rdata == mem_f(a), "R7", "read data", rsp_rdata, mem_f(a));
  endtask

  task automatic set_mode(input logic [1:0] m, input logic [1:0] s);
    @(negedge clk);
    cfg_mode = m; cfg_speed = s;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(ale == 0 && p0_oe == 0, "R1", "ale/oe at reset", {ale, p0_oe}, 0);
    chk(psen_n && rd_n && wr_n, "R1", "strobes at reset", {psen_n, rd_n, wr_n}, 7);
    chk(req_ready == 1 && rsp_done == 0, "R1", "ready/done at reset",
        {req_ready, rsp_done}, 2);
  endtask

  task automatic t_plain;
    set_mode(2'b00, 2'b00);
    access(16'h12A5, 0, 0, 8'h00, 0, 4, "R2");
    access(16'h12A6, 0, 1, 8'hC3, 0, 4, "R2");
    cfg_int_ale = 1'b0;
    access(16'h3401, 1, 0, 8'h00, 0, 4, "R4");
    set_mode(2'b11, 2'b00);
    access(16'h3401, 1, 0, 8'h00, 0, 4, "R2");
  endtask

  task automatic t_internal;
    set_mode(2'b00, 2'b00);
    cfg_int_ale = 1'b0;
    access(16'h0040, 1, 0, 8'h00, 1, 1, "R3");
    cfg_int_ale = 1'b1;
    access(16'h0041, 1, 0, 8'h00, 1, 1, "R3");
    access(16'h0042, 0, 1, 8'h11, 1, 1, "R3");
    access(16'h5502, 1, 0, 8'h00, 0, 4, "R4");
    cfg_int_ale = 1'b0;
  endtask

  task automatic t_page;
    set_mode(2'b01, 2'b00);
    access(16'h1234, 0, 0, 8'h00, 0, 2, "R9");
    access(16'h1290, 0, 0, 8'h00, 0, 1, "R12");
    set_mode(2'b01, 2'b01);
    access(16'h3400, 1, 0, 8'h00, 0, 4, "R8");
    access(16'h34FF, 0, 1, 8'h9E, 0, 2, "R8");
    set_mode(2'b01, 2'b10);
    access(16'h5610, 0, 0, 8'h00, 0, 8, "R8");
    access(16'h5611, 1, 0, 8'h00, 0, 4, "R8");
    access(16'h5711, 1, 0, 8'h00, 0, 8, "R9");
    set_mode(2'b00, 2'b10);
    set_mode(2'b01, 2'b10);
    access(16'h5712, 1, 0, 8'h00, 0, 8, "R9");
  endtask

  task automatic t_code_page;
    set_mode(2'b10, 2'b10);
    access(16'h7701, 0, 0, 8'h00, 0, 4, "R10");
    access(16'h7702, 0, 1, 8'h3C, 0, 4, "R10");
    access(16'h8803, 1, 0, 8'h00, 0, 8, "R10");
    access(16'h8804, 1, 0, 8'h00, 0, 4, "R10");
  endtask

  task automatic t_back_to_back;
    int n_done = 0, first_at = -1, second_at = -1;
    set_mode(2'b00, 2'b00);
    @(negedge clk);
    req_addr = 16'h2001; req_code = 1; req_write = 0; req_internal = 0;
    b_addr = 16'h2001; req_valid = 1'b1;
    @(posedge clk);
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      if (i == 1) begin req_addr = 16'h2102; b_addr = 16'h2102; end
      if (i == 5) req_valid = 1'b0;
      if (rsp_done) begin
        n_done++;
        if (first_at < 0) first_at = i; else if (second_at < 0) second_at = i;
      end
    end
    chk(first_at == 5, "R11", "first done index", first_at, 5);
    chk(second_at == 9, "R11", "second done index (no gap)", second_at, 9);
    chk(n_done == 2, "R11", "done pulses", n_done, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_internal();
    t_page();
    t_code_page();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule